// File: doc/BRIEF.md
# Serial FIFO DMA Request Controller

This block turns the fill levels of a serial port's transmit and receive FIFOs into request strobes for an external DMA engine. Each direction drives two requests. The single request asks for one transfer. The burst request asks for a block of `BURST_LEVEL` transfers. Each direction has its own enable bit, and that bit alone gates that direction's requests.

The block also holds completion status. When the DMA engine reports that a transfer has finished, a sticky raw bit is set for that direction. A live end-of-transmission bit reports when the transmit FIFO is empty and the shifter is idle. A registered interrupt line carries the masked OR of these status bits.

The transmit completion bit has a strict clear rule. A clear write is ignored while transmit DMA is enabled. Software must first disable transmit DMA and then write the clear. Software uses a four-entry register window to reach the enables, the masks, the status and the clear bits.

Top module: `sdma_req_ctrl`

## Requirements
- R1: `rxs_o` is 1 exactly when receive DMA is enabled (CTRL bit 0) and `rx_level_i` is at least 1. There is no clock delay.
- R2: `rxb_o` is 1 exactly when receive DMA is enabled and `rx_level_i` is at least `BURST_LEVEL` (4).
- R3: The transmit free-slot count is `FIFO_DEPTH` (8) minus `tx_level_i`. `txs_o` is 1 exactly when transmit DMA is enabled (CTRL bit 1) and the free-slot count is at least 1.
- R4: `txb_o` is 1 exactly when transmit DMA is enabled and the free-slot count is at least 4.
- R5: The two enable bits are independent. Writing CTRL (address 0) sets receive from bit 0 and transmit from bit 1, and each bit affects only its own direction's requests.
- R6: A one-cycle pulse on `tx_done_i` sets the transmit-complete status (STATUS bit 1) on the next clock edge. Writing 1 to CLEAR (address 3) bit 1 leaves it set while transmit DMA is enabled.
- R7: Once transmit DMA is disabled, a CLEAR bit 1 write clears the transmit-complete status. Transmit requests stay low until CTRL bit 1 is written to 1 again.
- R8: A pulse on `rx_done_i` sets the receive-complete status (STATUS bit 0). A CLEAR bit 0 write clears it whatever the enable state. If a clear and a new completion arrive in the same cycle, the bit is set.
- R9: STATUS bit 2 (end of transmission) is 1 exactly when `tx_level_i` is 0 and `shift_idle_i` is 1.
- R10: `irq_o` is registered. It equals the OR of STATUS bits ANDed with INTMASK (address 1) bits as they stood in the previous cycle.
- R11: After reset, CTRL, INTMASK, the completion bits and `irq_o` are 0. STATUS (address 2) and CLEAR read back as status and 0 respectively, and writes to STATUS do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address, used for both read and write |
| reg_wdata_i | input | 3 | Register write data |
| reg_rdata_o | output | 3 | Register read data, combinational on the address |
| rx_level_i | input | 4 | Receive FIFO fill level, 0 to FIFO_DEPTH |
| tx_level_i | input | 4 | Transmit FIFO fill level, 0 to FIFO_DEPTH |
| shift_idle_i | input | 1 | Shifter reports that its last bit has gone out |
| rx_done_i | input | 1 | DMA receive transfer complete pulse |
| tx_done_i | input | 1 | DMA transmit transfer complete pulse |
| rxs_o | output | 1 | Receive single request |
| rxb_o | output | 1 | Receive burst request |
| txs_o | output | 1 | Transmit single request |
| txb_o | output | 1 | Transmit burst request |
| irq_o | output | 1 | Masked interrupt, registered |

## Verification
The four requests and the end-of-transmission bit react to the levels and the idle input in the same cycle. The bench therefore sets these inputs on a falling edge and samples 1 ns later. Enable, mask and clear writes take effect at the rising edge inside the write. A completion pulse shows in STATUS at the edge that samples it. Both are checked on the falling edge that follows. `irq_o` lags the status and mask by one further edge, so the bench checks that it is still low one falling edge after the change and high on the next.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int unsigned REG_W = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_STATUS = 2'd2,
    ADDR_CLEAR  = 2'd3
  } reg_addr_e;

  localparam int unsigned BIT_RX  = 0;
  localparam int unsigned BIT_TX  = 1;
  localparam int unsigned BIT_EOT = 2;

  typedef struct packed {
    logic eot;
    logic tx_done;
    logic rx_done;
  } stat_t;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic [REG_W-1:0] mask_o,
  output logic             clr_rx_o,
  output logic             clr_tx_o
);
  reg_addr_e        addr;
  logic             ctrl_ce, mask_ce;
  logic [1:0]       ctrl_d, ctrl_q;
  logic [REG_W-1:0] mask_d, mask_q;

  always_comb begin
    addr     = reg_addr_e'(addr_i);
    ctrl_ce  = we_i && (addr == ADDR_CTRL);
    mask_ce  = we_i && (addr == ADDR_MASK);
    ctrl_d   = wdata_i[1:0];
    mask_d   = wdata_i;
    clr_rx_o = we_i && (addr == ADDR_CLEAR) && wdata_i[BIT_RX];
    clr_tx_o = we_i && (addr == ADDR_CLEAR) && wdata_i[BIT_TX];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end

  assign rx_en_o = ctrl_q[BIT_RX];
  assign tx_en_o = ctrl_q[BIT_TX];
  assign mask_o  = mask_q;
endmodule

// File: rtl/sdma_req_gen.sv
module sdma_req_gen #(
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned BURST_LEVEL = 4,
  parameter bit          COUNT_FREE  = 1'b0,
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             single_o,
  output logic             burst_o
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST_LEVEL);

  logic [LVL_W-1:0] avail;

  generate
    if (COUNT_FREE) begin : g_free
      assign avail = DEPTH_L - level_i;
    end else begin : g_fill
      assign avail = level_i;
    end
  endgenerate

  always_comb begin
    single_o = en_i && (avail != '0);
    burst_o  = en_i && (avail >= BURST_L);
  end
endmodule

// File: rtl/sdma_status.sv
module sdma_status
  import sdma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_done_i,
  input  logic             tx_done_i,
  input  logic             clr_rx_i,
  input  logic             clr_tx_i,
  input  logic             tx_en_i,
  input  logic             tx_empty_i,
  input  logic             shift_idle_i,
  input  logic [REG_W-1:0] mask_i,
  output stat_t            stat_o,
  output logic             irq_o
);
  logic rx_q, rx_d, rx_ce;
  logic tx_q, tx_d, tx_ce;
  logic tx_clr_ok;
  logic irq_q, irq_d;
  stat_t stat;

  always_comb begin
    tx_clr_ok = clr_tx_i && !tx_en_i;
    rx_ce     = rx_done_i || clr_rx_i;
    tx_ce     = tx_done_i || tx_clr_ok;
    rx_d      = rx_done_i;
    tx_d      = tx_done_i;
    stat.rx_done = rx_q;
    stat.tx_done = tx_q;
    stat.eot     = tx_empty_i && shift_idle_i;
    irq_d     = |(REG_W'(stat) & mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (rx_ce) rx_q <= rx_d;
      if (tx_ce) tx_q <= tx_d;
      irq_q <= irq_d;
    end
  end

  assign stat_o = stat;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sdma_req_ctrl.sv
module sdma_req_ctrl
  import sdma_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned BURST_LEVEL = 4,
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic             shift_idle_i,
  input  logic             rx_done_i,
  input  logic             tx_done_i,
  output logic             rxs_o,
  output logic             rxb_o,
  output logic             txs_o,
  output logic             txb_o,
  output logic             irq_o
);
  logic             rx_en, tx_en, clr_rx, clr_tx;
  logic [REG_W-1:0] mask;
  stat_t            stat;

  sdma_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rx_en_o  (rx_en),
    .tx_en_o  (tx_en),
    .mask_o   (mask),
    .clr_rx_o (clr_rx),
    .clr_tx_o (clr_tx)
  );

  sdma_req_gen #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .BURST_LEVEL(BURST_LEVEL),
    .COUNT_FREE (1'b0)
  ) u_rx_req (
    .en_i    (rx_en),
    .level_i (rx_level_i),
    .single_o(rxs_o),
    .burst_o (rxb_o)
  );

  sdma_req_gen #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .BURST_LEVEL(BURST_LEVEL),
    .COUNT_FREE (1'b1)
  ) u_tx_req (
    .en_i    (tx_en),
    .level_i (tx_level_i),
    .single_o(txs_o),
    .burst_o (txb_o)
  );

  sdma_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_done_i   (rx_done_i),
    .tx_done_i   (tx_done_i),
    .clr_rx_i    (clr_rx),
    .clr_tx_i    (clr_tx),
    .tx_en_i     (tx_en),
    .tx_empty_i  (tx_level_i == '0),
    .shift_idle_i(shift_idle_i),
    .mask_i      (mask),
    .stat_o      (stat),
    .irq_o       (irq_o)
  );

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_CTRL:   reg_rdata_o = {1'b0, tx_en, rx_en};
      ADDR_MASK:   reg_rdata_o = mask;
      ADDR_STATUS: reg_rdata_o = REG_W'(stat);
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sdma_req_ctrl_chk.sv
module sdma_req_ctrl_chk
  import sdma_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned BURST_LEVEL = 4,
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [LVL_W-1:0] tx_level_i,
  input logic             shift_idle_i,
  input logic             rx_done_i,
  input logic             tx_done_i,
  input logic             rxs_o,
  input logic             rxb_o,
  input logic             txs_o,
  input logic             txb_o,
  input logic             irq_o,
  input logic             tx_en,
  input logic [REG_W-1:0] mask,
  input stat_t            stat
);
  AST_RX_SINGLE_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxs_o |-> (rx_level_i != '0)); // R1
  AST_RX_BURST_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxb_o |-> (rxs_o && rx_level_i >= LVL_W'(BURST_LEVEL))); // R2
  AST_TX_SINGLE_HAS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txs_o |-> (tx_level_i < LVL_W'(FIFO_DEPTH))); // R3
  AST_TX_BURST_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txb_o |-> (txs_o && tx_level_i <= LVL_W'(FIFO_DEPTH - BURST_LEVEL))); // R4
  AST_TX_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> stat.tx_done); // R6
  AST_TX_DONE_HOLDS_WHILE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en && stat.tx_done) |=> stat.tx_done); // R6
  AST_TX_DONE_CLEARS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat.tx_done) |-> !$past(tx_en)); // R7
  AST_RX_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> stat.rx_done); // R8
  AST_EOT_MEANS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat.eot |-> (tx_level_i == '0 && shift_idle_i)); // R9
  AST_IRQ_FROM_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(REG_W'(stat) & mask))); // R10
endmodule

bind sdma_req_ctrl sdma_req_ctrl_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .BURST_LEVEL(BURST_LEVEL)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_level_i  (rx_level_i),
  .tx_level_i  (tx_level_i),
  .shift_idle_i(shift_idle_i),
  .rx_done_i   (rx_done_i),
  .tx_done_i   (tx_done_i),
  .rxs_o       (rxs_o),
  .rxb_o       (rxb_o),
  .txs_o       (txs_o),
  .txb_o       (txb_o),
  .irq_o       (irq_o),
  .tx_en       (tx_en),
  .mask        (mask),
  .stat        (stat)
);

// File: tb/sdma_req_ctrl_tb.sv
module sdma_req_ctrl_tb_top;
  localparam int DEPTH = 8;
  localparam int BURST = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [2:0] reg_wdata_i = 3'd0;
  logic [2:0] reg_rdata_o;
  logic [3:0] rx_level_i = 4'd0;
  logic [3:0] tx_level_i = 4'd0;
  logic       shift_idle_i = 1'b0;
  logic       rx_done_i = 1'b0;
  logic       tx_done_i = 1'b0;
  logic       rxs_o, rxb_o, txs_o, txb_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sdma_req_ctrl #(.FIFO_DEPTH(DEPTH), .BURST_LEVEL(BURST)) dut_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .rx_level_i, .tx_level_i, .shift_idle_i, .rx_done_i, .tx_done_i,
    .rxs_o, .rxb_o, .txs_o, .txb_o, .irq_o
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr_i = a;
    #1;
    v = int'(reg_rdata_o);
  endtask

  task automatic pulse_tx;
    @(negedge clk_i); tx_done_i = 1'b1;
    @(negedge clk_i); tx_done_i = 1'b0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    rd(2'd0, v); check("R11 ctrl", v, 0);
    rd(2'd1, v); check("R11 mask", v, 0);
    rd(2'd2, v); check("R11 status", v, 0);
    rd(2'd3, v); check("R11 clear reads 0", v, 0);
    check("R11 irq", irq_o, 0);
    check("R11 rxs", rxs_o, 0);
    check("R11 txs", txs_o, 0);

    // R1..R5 sweep of enables and both levels
    for (int en = 0; en < 4; en++) begin
      wr(2'd0, 3'(en));
      rd(2'd0, v); check("R5 ctrl readback", v, en);
      for (int rl = 0; rl <= DEPTH; rl++) begin
        for (int tl = 0; tl <= DEPTH; tl++) begin
          @(negedge clk_i);
          rx_level_i = 4'(rl); tx_level_i = 4'(tl);
          #1;
          check("R1 rx single", rxs_o, int'(en[0] && rl >= 1));
          check("R2 rx burst",  rxb_o, int'(en[0] && rl >= BURST));
          check("R3 tx single", txs_o, int'(en[1] && (DEPTH - tl) >= 1));
          check("R4 tx burst",  txb_o, int'(en[1] && (DEPTH - tl) >= BURST));
        end
      end
    end

    // R11 writes to STATUS ignored
    wr(2'd0, 3'd0);
    tx_level_i = 4'd3; shift_idle_i = 1'b0;
    wr(2'd2, 3'd7);
    rd(2'd2, v); check("R11 status write ignored", v, 0);

    // R6 transmit completion stays while enabled
    wr(2'd0, 3'd2);
    pulse_tx();
    rd(2'd2, v); check("R6 tx done set", v, 2);
    wr(2'd3, 3'd2);
    rd(2'd2, v); check("R6 clear ignored while enabled", v, 2);
    // R7 disable, then clear
    wr(2'd0, 3'd0);
    #1 check("R7 tx requests off", txs_o, 0);
    wr(2'd3, 3'd2);
    rd(2'd2, v); check("R7 tx done cleared", v, 0);
    #1 check("R7 still no request before re-enable", txs_o, 0);
    wr(2'd0, 3'd2);
    #1 check("R7 request after re-enable", txs_o, 1);
    check("R5 rx unaffected by tx enable", rxs_o, 0);

    // R8 receive completion
    wr(2'd0, 3'd3);
    @(negedge clk_i); rx_done_i = 1'b1;
    @(negedge clk_i); rx_done_i = 1'b0;
    rd(2'd2, v); check("R8 rx done set", v, 1);
    wr(2'd3, 3'd1);
    rd(2'd2, v); check("R8 rx cleared while enabled", v, 0);
    @(negedge clk_i);
    rx_done_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 3'd1;
    @(negedge clk_i);
    rx_done_i = 1'b0; reg_we_i = 1'b0;
    rd(2'd2, v); check("R8 set wins over clear", v, 1);
    wr(2'd3, 3'd1);
    rd(2'd2, v); check("R8 cleared again", v, 0);

    // R9 end of transmission
    @(negedge clk_i); tx_level_i = 4'd0; shift_idle_i = 1'b1;
    rd(2'd2, v); check("R9 eot empty and idle", v, 4);
    @(negedge clk_i); tx_level_i = 4'd1;
    rd(2'd2, v); check("R9 eot not empty", v, 0);
    @(negedge clk_i); tx_level_i = 4'd0; shift_idle_i = 1'b0;
    rd(2'd2, v); check("R9 eot not idle", v, 0);

    // R10 registered masked interrupt
    @(negedge clk_i); shift_idle_i = 1'b1;
    @(negedge clk_i);
    check("R10 unmasked eot gives no irq", irq_o, 0);
    wr(2'd1, 3'd4);
    check("R10 irq one edge later", irq_o, 0);
    @(negedge clk_i);
    check("R10 irq raised", irq_o, 1);
    tx_level_i = 4'd2;
    @(negedge clk_i);
    check("R10 irq follows eot drop", irq_o, 0);
    wr(2'd1, 3'd2);
    pulse_tx();
    check("R10 irq from tx done lags", irq_o, 0);
    @(negedge clk_i);
    check("R10 irq from tx done", irq_o, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule